// File: doc/BRIEF.md
# Array Store Address Unit

This block forms store addresses for streamed array writes next to a load/store pipeline. It keeps a bank of array descriptors, a bank of store index registers and a bank of increment registers. Each decoded store-array command carries an operand value, a command word with register selectors and mode flags, an access-mode code, a channel number and an opcode. With access-mode code zero the command stores its operand to memory at descriptor base plus index plus literal, and can advance the index afterwards. With access-mode code 0x3F the same command loads a descriptor or an index register from the operand instead.

Commands arrive one at a time through a valid/ready pair. A store turns into a single write request on a valid/ready memory port; no further command is accepted until that request is taken. Illegal channels or opcodes, absent literals and unsupported modes raise a one-cycle exception with a code and change no state.

Top module: `arr_store_addr`

## Requirements
- R1: After reset no write request or exception is pending, the command port is ready, and every descriptor base, index register and increment register reads as zero.
- R2: Command word fields: literal selector bits 9:8, step flag bit 10, increment select bits 14:12, index select bits 18:15, descriptor select bits 23:19, speculative flag bit 31. A store (mode 0) issues a write request one cycle after acceptance to address (base + index + literal) truncated to 48 bits.
- R3: Opcode 0x1F stores the whole 64-bit operand with byte strobe 0xFF; opcode 0x1E stores the low 32 bits, zero-extended, with byte strobe 0x0F (byte 0 at the lowest address).
- R4: Mode 0x3F with the step flag clear loads the selected descriptor base from operand bits 47:0 (0x1F) or 31:0 zero-extended (0x1E), sets its rights field to 3 and sets the selected increment register to 1.
- R5: Mode 0x3F with the step flag set loads the selected index register from operand bits 31:0.
- R6: A store with the step flag set adds the selected increment times 8 (0x1F) or 4 (0x1E) to the selected index, modulo 2^32, in the cycle its write request is accepted.
- R7: A write request holds its address, data and strobe until accepted, and the command port is not ready while a request is pending.
- R8: Literal selector 0 means a literal of zero; selectors 1 to 3 pick literal slot selector-1. A selected slot not marked present raises exception code 1 and the command has no effect.
- R9: An opcode other than 0x1E/0x1F, or a channel other than 2 or 5, raises exception code 2 and the command has no effect.
- R10: A mode other than 0 or 0x3F, or a set speculative flag, raises exception code 3 and the command has no effect.
- R11: Exception priority: code 2 over code 1 over code 3. The exception pulse lasts one cycle, one cycle after acceptance, and no write request accompanies it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_opc | input | 7 | Opcode (0x1E word, 0x1F doubleword) |
| cmd_chan | input | 3 | Issue channel |
| cmd_mode | input | 6 | Access-mode code |
| cmd_word | input | 32 | Command word with selectors and flags |
| cmd_operand | input | 64 | Operand value |
| lit_vals | input | 96 | Three 32-bit literal slots, slot k at bits 32k+31:32k |
| lit_present | input | 3 | Presence flag per literal slot |
| mem_wvalid | output | 1 | Write request valid |
| mem_wready | input | 1 | Write request taken |
| mem_waddr | output | 48 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_wstrb | output | 8 | Byte enables |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 2 | 1 illegal operand, 2 illegal opcode, 3 unimplemented |

## Verification
The bench targets index stepping only on write acceptance: a design that stepped on command acceptance would still pass a single store but shift the next address when memory stalls. It probes word-form scaling by 4 against 8, where a fixed scale gives addresses off by half or double the stride, and word-form descriptor loading, where copying upper operand bits corrupts the base. Exception priority is driven with two faults at once, so a swapped decode order returns the wrong code, and every rejected command is followed by stores that would expose any register it changed.

// File: rtl/arr_store_addr.sv
module arr_store_addr #(
  parameter int NDESC  = 32,
  parameter int NIDX   = 16,
  parameter int NINC   = 8,
  parameter int BASE_W = 48,
  parameter int IDX_W  = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [6:0]        cmd_opc,
  input  logic [2:0]        cmd_chan,
  input  logic [5:0]        cmd_mode,
  input  logic [31:0]       cmd_word,
  input  logic [DATA_W-1:0] cmd_operand,
  input  logic [95:0]       lit_vals,
  input  logic [2:0]        lit_present,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [BASE_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W/8-1:0] mem_wstrb,
  output logic              exc_valid,
  output logic [1:0]        exc_code
);
  localparam int DS_W = $clog2(NDESC);
  localparam int XS_W = $clog2(NIDX);
  localparam int IS_W = $clog2(NINC);
  localparam int SB_W = DATA_W / 8;

  logic [BASE_W-1:0]          base_q [NDESC];
  logic [NDESC-1:0][1:0]      rw_q;
  logic [IDX_W-1:0]           idx_q  [NIDX];
  logic [IDX_W-1:0]           inc_q  [NINC];

  logic                       wv_q, step_q;
  logic [XS_W-1:0]            step_sel_q;
  logic [IDX_W-1:0]           step_amt_q;
  logic [BASE_W-1:0]          waddr_q;
  logic [DATA_W-1:0]          wdata_q;
  logic [SB_W-1:0]            wstrb_q;
  logic                       exc_q;
  logic [1:0]                 code_q;

  wire [1:0]      f_lit  = cmd_word[9:8];
  wire            f_step = cmd_word[10];
  wire [IS_W-1:0] f_inc  = cmd_word[12 +: IS_W];
  wire [XS_W-1:0] f_idx  = cmd_word[15 +: XS_W];
  wire [DS_W-1:0] f_desc = cmd_word[19 +: DS_W];
  wire            f_spec = cmd_word[31];

  logic unused_bits;
  assign unused_bits = ^{cmd_word[7:0], cmd_word[11], cmd_word[30:24]};

  wire is_dword = cmd_opc == 7'h1F;
  wire opc_ok   = cmd_opc[6:1] == 6'h0F;
  wire chan_ok  = cmd_chan == 3'd2 || cmd_chan == 3'd5;
  wire lit_ok   = f_lit == 2'd0 || lit_present[f_lit - 2'd1];
  wire mode_st  = cmd_mode == 6'h00;
  wire mode_pg  = cmd_mode == 6'h3F;
  wire accept   = cmd_valid && cmd_ready;

  logic [31:0] lit_word;
  always_comb begin
    case (f_lit)
      2'd1:    lit_word = lit_vals[31:0];
      2'd2:    lit_word = lit_vals[63:32];
      2'd3:    lit_word = lit_vals[95:64];
      default: lit_word = 32'd0;
    endcase
  end

  logic [1:0] code_n;
  always_comb begin
    if (!opc_ok || !chan_ok)               code_n = 2'd2;
    else if (!lit_ok)                      code_n = 2'd1;
    else if (f_spec || !(mode_st || mode_pg)) code_n = 2'd3;
    else                                   code_n = 2'd0;
  end

  wire [BASE_W-1:0] st_addr = base_q[f_desc] + BASE_W'(idx_q[f_idx]) + BASE_W'(lit_word);
  wire [IDX_W-1:0]  st_step = is_dword ? (inc_q[f_inc] << 3) : (inc_q[f_inc] << 2);
  wire [BASE_W-1:0] pg_base = is_dword ? cmd_operand[BASE_W-1:0] : BASE_W'(cmd_operand[31:0]);

  assign cmd_ready  = !wv_q;
  assign mem_wvalid = wv_q;
  assign mem_waddr  = waddr_q;
  assign mem_wdata  = wdata_q;
  assign mem_wstrb  = wstrb_q;
  assign exc_valid  = exc_q;
  assign exc_code   = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) base_q[i] <= '0;
      for (int i = 0; i < NIDX; i++)  idx_q[i]  <= '0;
      for (int i = 0; i < NINC; i++)  inc_q[i]  <= '0;
      rw_q       <= '0;
      wv_q       <= 1'b0;
      step_q     <= 1'b0;
      step_sel_q <= '0;
      step_amt_q <= '0;
      waddr_q    <= '0;
      wdata_q    <= '0;
      wstrb_q    <= '0;
      exc_q      <= 1'b0;
      code_q     <= 2'd0;
    end else begin
      exc_q <= 1'b0;
      if (accept) begin
        if (code_n != 2'd0) begin
          exc_q  <= 1'b1;
          code_q <= code_n;
        end else if (mode_st) begin
          wv_q       <= 1'b1;
          waddr_q    <= st_addr;
          wdata_q    <= is_dword ? cmd_operand : DATA_W'(cmd_operand[31:0]);
          wstrb_q    <= is_dword ? {SB_W{1'b1}} : SB_W'({(SB_W/2){1'b1}});
          step_q     <= f_step;
          step_sel_q <= f_idx;
          step_amt_q <= st_step;
        end else if (!f_step) begin
          base_q[f_desc] <= pg_base;
          rw_q[f_desc]   <= 2'd3;
          inc_q[f_inc]   <= IDX_W'(1);
        end else begin
          idx_q[f_idx] <= cmd_operand[IDX_W-1:0];
        end
      end
      if (wv_q && mem_wready) begin
        wv_q <= 1'b0;
        if (step_q) idx_q[step_sel_q] <= idx_q[step_sel_q] + step_amt_q;
      end
    end
  end
endmodule

// File: rtl/arr_store_addr_chk.sv
module arr_store_addr_chk #(
  parameter int NDESC  = 32,
  parameter int BASE_W = 48,
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [6:0]          cmd_opc,
  input logic [2:0]          cmd_chan,
  input logic [5:0]          cmd_mode,
  input logic [31:0]         cmd_word,
  input logic                mem_wvalid,
  input logic                mem_wready,
  input logic [BASE_W-1:0]   mem_waddr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic [DATA_W/8-1:0] mem_wstrb,
  input logic                exc_valid,
  input logic [1:0]          exc_code,
  input logic [NDESC-1:0][1:0] rw_q
);
  wire acc     = cmd_valid && cmd_ready;
  wire good_oc = (cmd_opc == 7'h1E || cmd_opc == 7'h1F) && (cmd_chan == 3'd2 || cmd_chan == 3'd5);
  wire clean   = good_oc && cmd_word[9:8] == 2'd0 && !cmd_word[31];

  a_r1_exc_code: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> exc_code != 2'd0);

  a_r3_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> (mem_wstrb == 8'hFF || (mem_wstrb == 8'h0F && mem_wdata[63:32] == 32'd0)));

  a_r4_rights: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && clean && cmd_mode == 6'h3F && !cmd_word[10]) |=> rw_q[$past(cmd_word[23:19])] == 2'd3);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata) && $stable(mem_wstrb)));

  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> !cmd_ready);

  a_r9_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !good_oc) |=> (exc_valid && exc_code == 2'd2 && !mem_wvalid));

  a_r10_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && clean && cmd_mode != 6'h00 && cmd_mode != 6'h3F) |=> (exc_valid && exc_code == 2'd3 && !mem_wvalid));

  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid);
endmodule

bind arr_store_addr arr_store_addr_chk #(.NDESC(NDESC), .BASE_W(BASE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_opc(cmd_opc), .cmd_chan(cmd_chan), .cmd_mode(cmd_mode), .cmd_word(cmd_word),
  .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
  .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .exc_valid(exc_valid),
  .exc_code(exc_code), .rw_q(rw_q)
);

// File: tb/arr_store_addr_tb.sv
module arr_store_addr_tb;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_ready;
  logic [6:0]  cmd_opc = 0;
  logic [2:0]  cmd_chan = 0;
  logic [5:0]  cmd_mode = 0;
  logic [31:0] cmd_word = 0;
  logic [63:0] cmd_operand = 0;
  logic [95:0] lit_vals = 0;
  logic [2:0]  lit_present = 0;
  logic        mem_wvalid, mem_wready = 0;
  logic [47:0] mem_waddr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_wstrb;
  logic        exc_valid;
  logic [1:0]  exc_code;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [47:0] m_base [32];
  logic [31:0] m_idx  [16];
  logic [31:0] m_inc  [8];

  arr_store_addr u_dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int lit, input int stp, input int inc, input int idx, input int dsc, input int spec);
    return {spec[0], 7'($urandom), dsc[4:0], idx[3:0], inc[2:0], 1'($urandom), stp[0], lit[1:0], 8'($urandom)};
  endfunction

  function automatic logic [1:0] exp_code(input logic [6:0] opc, input logic [2:0] ch, input logic [5:0] md,
                                          input logic [31:0] w, input logic [2:0] pres);
    if (!(opc == 7'h1E || opc == 7'h1F) || !(ch == 3'd2 || ch == 3'd5)) return 2'd2;
    if (w[9:8] != 2'd0 && !pres[w[9:8] - 2'd1]) return 2'd1;
    if (w[31] || !(md == 6'h00 || md == 6'h3F)) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [31:0] lit_of(input logic [1:0] s);
    case (s)
      2'd1: return lit_vals[31:0];
      2'd2: return lit_vals[63:32];
      2'd3: return lit_vals[95:64];
      default: return 32'd0;
    endcase
  endfunction

  task automatic run(input logic [6:0] opc, input logic [2:0] ch, input logic [5:0] md,
                     input logic [31:0] w, input logic [63:0] op, input string req, input int stall);
    logic [1:0] ec;
    logic [47:0] ea;
    logic [63:0] ed;
    logic [7:0] es;
    bit dw;
    ec = exp_code(opc, ch, md, w, lit_present);
    dw = opc == 7'h1F;
    ea = m_base[w[23:19]] + 48'(m_idx[w[18:15]]) + 48'(lit_of(w[9:8]));
    ed = dw ? op : {32'd0, op[31:0]};
    es = dw ? 8'hFF : 8'h0F;
    chk(cmd_ready, {req, " ready"}, 64'(cmd_ready), 1);
    cmd_opc = opc; cmd_chan = ch; cmd_mode = md; cmd_word = w; cmd_operand = op; cmd_valid = 1;
    @(posedge clk); #1;
    cmd_valid = 0;
    if (ec != 0) begin
      chk(exc_valid && exc_code == ec && !mem_wvalid, {req, " exception"}, {exc_valid, mem_wvalid, exc_code}, {2'b10, ec});
      @(posedge clk); #1;
      chk(!exc_valid, "R11 one-cycle pulse", 64'(exc_valid), 0);
    end else if (md == 6'h00) begin
      chk(mem_wvalid && !exc_valid, {req, " R2 request"}, 64'(mem_wvalid), 1);
      chk(mem_waddr == ea, {req, " R2 address"}, 64'(mem_waddr), 64'(ea));
      chk(mem_wdata == ed && mem_wstrb == es, {req, " R3 data/strobe"}, mem_wdata ^ 64'(mem_wstrb), ed ^ 64'(es));
      for (int k = 0; k < stall; k++) begin
        @(posedge clk); #1;
        chk(mem_wvalid && !cmd_ready && mem_waddr == ea, "R7 held while stalled", 64'(mem_waddr), 64'(ea));
      end
      mem_wready = 1;
      @(posedge clk); #1;
      mem_wready = 0;
      chk(!mem_wvalid, "R7 request retired", 64'(mem_wvalid), 0);
      if (w[10]) m_idx[w[18:15]] = m_idx[w[18:15]] + (dw ? m_inc[w[14:12]] << 3 : m_inc[w[14:12]] << 2);
    end else begin
      chk(!mem_wvalid && !exc_valid, {req, " program silent"}, {mem_wvalid, exc_valid}, 0);
      if (!w[10]) begin
        m_base[w[23:19]] = dw ? op[47:0] : {16'd0, op[31:0]};
        m_inc[w[14:12]] = 1;
      end else m_idx[w[18:15]] = op[31:0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) m_base[i] = 0;
    for (int i = 0; i < 16; i++) m_idx[i] = 0;
    for (int i = 0; i < 8; i++)  m_inc[i] = 0;
    lit_vals = {32'h300, 32'h20, 32'h4};
    lit_present = 3'b111;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;
    chk(!mem_wvalid && !exc_valid && cmd_ready, "R1 reset outputs", {mem_wvalid, exc_valid, cmd_ready}, 1);
    // R1: zero registers -> address equals literal only
    run(7'h1F, 3'd2, 6'h00, mk(2, 1, 3, 7, 9, 0), 64'h1122334455667788, "R1 zero state", 0);
    run(7'h1F, 3'd5, 6'h00, mk(0, 0, 3, 7, 9, 0), 64'h55, "R6 zero increment", 0);
    // R4 doubleword descriptor drops bits above 47
    run(7'h1F, 3'd2, 6'h3F, mk(0, 0, 2, 0, 4, 0), 64'hABCD_0000_1000_0000, "R4 dword base", 0);
    run(7'h1F, 3'd2, 6'h00, mk(1, 0, 0, 0, 4, 0), 64'h77, "R4 base check", 0);
    // R4 word descriptor drops bits above 31
    run(7'h1E, 3'd5, 6'h3F, mk(0, 0, 5, 0, 6, 0), 64'hFFFF_FFFF_8000_0000, "R4 word base", 0);
    // R5 index load, R6 word step by 4 with stall
    run(7'h1E, 3'd2, 6'h3F, mk(0, 1, 0, 3, 0, 0), 64'h1_0000_0010, "R5 index load", 0);
    run(7'h1E, 3'd2, 6'h00, mk(3, 1, 5, 3, 6, 0), 64'hDEAD_BEEF_CAFE_F00D, "R6 word step", 2);
    run(7'h1E, 3'd2, 6'h00, mk(0, 1, 5, 3, 6, 0), 64'h1, "R6 word step 2", 1);
    run(7'h1F, 3'd5, 6'h00, mk(0, 1, 2, 3, 6, 0), 64'h2, "R6 dword step", 3);
    run(7'h1F, 3'd5, 6'h00, mk(0, 0, 2, 3, 6, 0), 64'h3, "R6 after dword step", 0);
    // R8 absent literal, then prove nothing changed
    lit_present = 3'b101;
    run(7'h1F, 3'd2, 6'h3F, mk(2, 1, 0, 3, 0, 0), 64'h999, "R8 absent literal", 0);
    run(7'h1F, 3'd2, 6'h00, mk(1, 0, 0, 3, 6, 0), 64'h4, "R8 no effect", 0);
    // R9
    run(7'h1F, 3'd0, 6'h3F, mk(0, 0, 0, 0, 6, 0), 64'h5, "R9 bad channel", 0);
    run(7'h1D, 3'd2, 6'h3F, mk(0, 1, 0, 3, 0, 0), 64'h5, "R9 bad opcode", 0);
    run(7'h1F, 3'd5, 6'h00, mk(0, 0, 0, 3, 6, 0), 64'h6, "R9 no effect", 0);
    // R10
    run(7'h1F, 3'd2, 6'h10, mk(0, 0, 0, 0, 6, 0), 64'h7, "R10 bad mode", 0);
    run(7'h1E, 3'd2, 6'h3F, mk(0, 1, 0, 3, 0, 1), 64'h7, "R10 speculative", 0);
    run(7'h1F, 3'd5, 6'h00, mk(0, 0, 0, 3, 6, 0), 64'h8, "R10 no effect", 0);
    // R11 priority
    run(7'h1F, 3'd1, 6'h22, mk(2, 0, 0, 0, 0, 1), 64'h9, "R11 opcode over literal", 0);
    run(7'h1F, 3'd2, 6'h22, mk(2, 0, 0, 0, 0, 1), 64'h9, "R11 literal over mode", 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [6:0] o;
      logic [2:0] c;
      logic [5:0] m;
      int r;
      lit_vals = {$urandom, $urandom, $urandom};
      lit_present = 3'($urandom) | 3'($urandom);
      r = $urandom_range(0, 19);
      o = (r == 0) ? 7'($urandom) : (($urandom & 1) ? 7'h1F : 7'h1E);
      c = (r == 1) ? 3'($urandom) : (($urandom & 1) ? 3'd2 : 3'd5);
      r = $urandom_range(0, 9);
      m = (r < 6) ? 6'h00 : (r < 9) ? 6'h3F : 6'($urandom);
      run(o, c, m, mk($urandom_range(0, 3), $urandom & 1, $urandom_range(0, 7), $urandom_range(0, 15),
                      $urandom_range(0, 31), ($urandom_range(0, 15) == 0) ? 1 : 0),
          {$urandom, $urandom}, "R2 random", $urandom_range(0, 2));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule